// File: doc/BRIEF.md
# Paged Memory Management Unit

This block sits between an 8-bit CPU with a 16-bit address bus and a large physical memory. It splits the CPU's 64 KiB space into sixteen 4 KiB pages. Each CPU access looks up one 16-bit mapping entry, and that entry supplies a 14-bit physical page number. Together with the 12 untouched offset bits, this forms a 26-bit physical address. Two flag bits in each entry can block writes to the page or raise an interrupt when the page is touched.

The entries are grouped into mapping sets of sixteen, one entry for each CPU page. The block holds many sets (256 by default). One selector picks the set used for translation. A second, independent selector picks the set that software sees in its edit window. A quick-select range of register offsets makes any of the first sixteen sets active with a single write. The same physical page may appear any number of times, in any set and at any CPU page.

Software reaches the registers by asserting the register-select strobe. During such an access, the low address byte is the register offset. After reset the block fills every set with an identity map, one entry per cycle. Until that fill completes, writes to mapping entries are dropped.

Top module: `page_mmu`

## Requirements
- R1: After reset the block is disabled, both set selectors read 0 and the interrupt is low. Once the fill has run (NUM_SETS*16 cycles), entry n of every set holds physical page n with both flag bits clear.
- R2: While disabled, phys_addr equals cpu_addr zero-extended to 26 bits. Every memory write passes (phys_we high, phys_wp low), and no access raises the interrupt.
- R3: While enabled, phys_addr = {ppn, cpu_addr[11:0]}. Here ppn is bits 13:0 of entry cpu_addr[15:12] of the active set.
- R4: Offset 0x00 is the control register. A write sets the enable from wdata bit 0, and a write with wdata bit 1 set clears a pending interrupt. A read returns {6'b0, irq, enable}.
- R5: Offset 0x01 holds the edit-set number and offset 0x02 the active-set number. Both are 8-bit read/write, and each changes only when it is itself written.
- R6: Offset 0x10+n reads and writes bits 7:0 of entry n of the edit set. Offset 0x20+n reads and writes bits 15:8 of the same entry. Read data is valid in the same cycle as the read access.
- R7: A write to offset 0xE0+n (n = 0..15) makes set n active and leaves the edit set unchanged.
- R8: Entry bit 15 is write-protect. While enabled, a memory write to such a page gives phys_we low and phys_wp high. Reads of the page, and writes to unprotected pages, give phys_wp low, and phys_we follows cpu_we.
- R9: Entry bit 14 is interrupt-on-access. While enabled, any memory access to such a page drives irq high from the next cycle. irq stays high until it is cleared through R4.
- R10: A register access (reg_sel high) never asserts phys_we or phys_wp and never raises the interrupt, whatever the upper address byte holds.
- R11: Several entries, in the same set or in different sets, may name the same physical page. Each one translates to that page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | A CPU access is present this cycle |
| reg_sel | input | 1 | The access targets the register window |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address; bits 7:0 are the register offset when reg_sel is high |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Register read data, 0 outside register reads |
| phys_addr | output | 26 | Translated physical address |
| phys_we | output | 1 | Write enable toward physical memory |
| phys_wp | output | 1 | A write was blocked by write-protect |
| irq | output | 1 | Level interrupt, pending access to a flagged page |

## Verification
The bench reads back every entry of every set through the edit window, so a fill that skips addresses or stops one entry early shows up as a non-identity entry. It sweeps all sixteen pages with enable off and on, checking that write-protect blocks only the flagged page and only while enabled; a design that gated protection wrongly would block writes while disabled or let them through on page 4. It checks that the edit and active selectors stay independent and that quick-select does not disturb the edit set. It also checks that a register access aimed at an address whose high byte names an interrupt page does not raise irq, and that a control write without the clear bit leaves irq set.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int CPU_AW    = 16;
    localparam int OFF_W     = 12;
    localparam int PAGE_IW   = CPU_AW - OFF_W;
    localparam int NUM_PAGES = 1 << PAGE_IW;
    localparam int PPN_W     = 14;
    localparam int PA_W      = PPN_W + OFF_W;
    localparam int ENTRY_W   = 16;
    localparam int LANES     = ENTRY_W / 8;

    typedef struct packed {
        logic             wprot;
        logic             irq_en;
        logic [PPN_W-1:0] ppn;
    } map_entry_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_EDIT,
        RK_ACTIVE,
        RK_LO,
        RK_HI,
        RK_QUICK
    } reg_kind_t;

    typedef struct packed {
        reg_kind_t                kind;
        logic [PAGE_IW-1:0]       idx;
    } reg_dec_t;

    function automatic reg_dec_t decode_offset(input logic [7:0] off);
        reg_dec_t d;
        d.idx  = off[3:0];
        d.kind = RK_NONE;
        case (off[7:4])
            4'h0: begin
                case (off[3:0])
                    4'h0:    d.kind = RK_CTRL;
                    4'h1:    d.kind = RK_EDIT;
                    4'h2:    d.kind = RK_ACTIVE;
                    default: d.kind = RK_NONE;
                endcase
            end
            4'h1:    d.kind = RK_LO;
            4'h2:    d.kind = RK_HI;
            4'hE:    d.kind = RK_QUICK;
            default: d.kind = RK_NONE;
        endcase
        return d;
    endfunction

    function automatic map_entry_t identity_entry(input logic [PAGE_IW-1:0] n);
        map_entry_t e;
        e.wprot  = 1'b0;
        e.irq_en = 1'b0;
        e.ppn    = PPN_W'(n);
        return e;
    endfunction

endpackage

// File: rtl/mmu_map_ram.sv
module mmu_map_ram
    import mmu_pkg::*;
#(
    parameter int SET_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [SET_W-1:0]      wr_set,
    input  logic [PAGE_IW-1:0]    wr_idx,
    input  logic [LANES-1:0]      wr_lane,
    input  logic [7:0]            wr_byte,
    input  logic [SET_W-1:0]      ta_set,
    input  logic [PAGE_IW-1:0]    ta_idx,
    output map_entry_t            ta_entry,
    input  logic [SET_W-1:0]      ed_set,
    input  logic [PAGE_IW-1:0]    ed_idx,
    output map_entry_t            ed_entry
);

    localparam int AW    = SET_W + PAGE_IW;
    localparam int DEPTH = 1 << AW;

    logic [AW-1:0]      fill_ptr;
    logic               fill_busy;
    map_entry_t         fill_val;
    logic [AW-1:0]      wr_addr, ta_addr, ed_addr;
    logic [ENTRY_W-1:0] ta_bits, ed_bits;

    assign fill_val = identity_entry(fill_ptr[PAGE_IW-1:0]);
    assign wr_addr  = {wr_set, wr_idx};
    assign ta_addr  = {ta_set, ta_idx};
    assign ed_addr  = {ed_set, ed_idx};

    // Background identity fill after reset, one entry per cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_ptr  <= '0;
            fill_busy <= 1'b1;
        end else if (fill_busy) begin
            fill_ptr <= fill_ptr + 1'b1;
            if (fill_ptr == AW'(DEPTH - 1))
                fill_busy <= 1'b0;
        end
    end

    // One byte-wide storage array per lane
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [7:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (fill_busy && !rst)
                store[fill_ptr] <= fill_val[ln*8 +: 8];
            else if (wr_en && wr_lane[ln] && !rst)
                store[wr_addr] <= wr_byte;
        end

        assign ta_bits[ln*8 +: 8] = store[ta_addr];
        assign ed_bits[ln*8 +: 8] = store[ed_addr];
    end

    assign ta_entry = map_entry_t'(ta_bits);
    assign ed_entry = map_entry_t'(ed_bits);

endmodule

// File: rtl/mmu_regs.sv
module mmu_regs
    import mmu_pkg::*;
#(
    parameter int SET_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         off,
    input  logic [7:0]         wdata,
    input  logic               irq_trig,
    input  map_entry_t         ed_entry,
    output logic               enable,
    output logic [SET_W-1:0]   edit_set,
    output logic [SET_W-1:0]   active_set,
    output logic               irq,
    output logic [7:0]         rdata,
    output logic               map_wr,
    output logic [PAGE_IW-1:0] map_idx,
    output logic [LANES-1:0]   map_lane
);

    reg_dec_t dec;
    logic     irq_clr;

    assign dec      = decode_offset(off);
    assign irq_clr  = reg_wr && dec.kind == RK_CTRL && wdata[1];
    assign map_wr   = reg_wr && (dec.kind == RK_LO || dec.kind == RK_HI);
    assign map_idx  = dec.idx;
    assign map_lane = {dec.kind == RK_HI, dec.kind == RK_LO};

    always_ff @(posedge clk) begin
        if (rst) begin
            enable     <= 1'b0;
            edit_set   <= '0;
            active_set <= '0;
        end else if (reg_wr) begin
            case (dec.kind)
                RK_CTRL:   enable     <= wdata[0];
                RK_EDIT:   edit_set   <= wdata[SET_W-1:0];
                RK_ACTIVE: active_set <= wdata[SET_W-1:0];
                RK_QUICK:  active_set <= SET_W'(dec.idx);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (irq_trig)
            irq <= 1'b1;
        else if (irq_clr)
            irq <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        if (reg_rd) begin
            case (dec.kind)
                RK_CTRL:   rdata = {6'b0, irq, enable};
                RK_EDIT:   rdata = 8'(edit_set);
                RK_ACTIVE: rdata = 8'(active_set);
                RK_LO:     rdata = ed_entry[7:0];
                RK_HI:     rdata = ed_entry[15:8];
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
(
    input  logic              enable,
    input  map_entry_t        entry,
    input  logic              mem_acc,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [PA_W-1:0]   phys_addr,
    output logic              phys_we,
    output logic              wp_hit,
    output logic              irq_trig
);

    logic blocked, flagged;

    always_comb begin
        if (enable) begin
            phys_addr = {entry.ppn, cpu_addr[OFF_W-1:0]};
            blocked   = entry.wprot;
            flagged   = entry.irq_en;
        end else begin
            phys_addr = PA_W'(cpu_addr);
            blocked   = 1'b0;
            flagged   = 1'b0;
        end
    end

    assign phys_we  = mem_acc && cpu_we && !blocked;
    assign wp_hit   = mem_acc && cpu_we && blocked;
    assign irq_trig = mem_acc && flagged;

endmodule

// File: rtl/page_mmu.sv
module page_mmu
    import mmu_pkg::*;
#(
    parameter int NUM_SETS = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_valid,
    input  logic        reg_sel,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic [25:0] phys_addr,
    output logic        phys_we,
    output logic        phys_wp,
    output logic        irq
);

    localparam int SET_W = $clog2(NUM_SETS);

    logic               en_q;
    logic [SET_W-1:0]   edit_q, act_q;
    logic               reg_wr, reg_rd, mem_acc;
    logic               map_wr, irq_trig;
    logic [PAGE_IW-1:0] map_idx;
    logic [LANES-1:0]   map_lane;
    map_entry_t         ta_entry, ed_entry;

    assign reg_wr  = cpu_valid && reg_sel && cpu_we;
    assign reg_rd  = cpu_valid && reg_sel && !cpu_we;
    assign mem_acc = cpu_valid && !reg_sel;

    mmu_regs #(.SET_W(SET_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .off        (cpu_addr[7:0]),
        .wdata      (cpu_wdata),
        .irq_trig   (irq_trig),
        .ed_entry   (ed_entry),
        .enable     (en_q),
        .edit_set   (edit_q),
        .active_set (act_q),
        .irq        (irq),
        .rdata      (cpu_rdata),
        .map_wr     (map_wr),
        .map_idx    (map_idx),
        .map_lane   (map_lane)
    );

    mmu_map_ram #(.SET_W(SET_W)) u_ram (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (map_wr),
        .wr_set   (edit_q),
        .wr_idx   (map_idx),
        .wr_lane  (map_lane),
        .wr_byte  (cpu_wdata),
        .ta_set   (act_q),
        .ta_idx   (cpu_addr[15:12]),
        .ta_entry (ta_entry),
        .ed_set   (edit_q),
        .ed_idx   (cpu_addr[3:0]),
        .ed_entry (ed_entry)
    );

    mmu_xlate u_xlate (
        .enable    (en_q),
        .entry     (ta_entry),
        .mem_acc   (mem_acc),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .phys_addr (phys_addr),
        .phys_we   (phys_we),
        .wp_hit    (phys_wp),
        .irq_trig  (irq_trig)
    );

endmodule

// File: rtl/page_mmu_chk.sv
module page_mmu_chk #(
    parameter int SET_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_valid,
    input logic             reg_sel,
    input logic             cpu_we,
    input logic [15:0]      cpu_addr,
    input logic [7:0]       cpu_wdata,
    input logic [25:0]      phys_addr,
    input logic             phys_we,
    input logic             phys_wp,
    input logic             irq,
    input logic             enable,
    input logic [SET_W-1:0] active_set
);

    logic ctrl_clear;
    assign ctrl_clear = cpu_valid && reg_sel && cpu_we &&
                        cpu_addr[7:0] == 8'h00 && cpu_wdata[1];

    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (rst)
        phys_addr[11:0] == cpu_addr[11:0]);

    assert_disabled_flat_R2: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (phys_addr == 26'(cpu_addr) && !phys_wp));

    assert_reg_no_side_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && reg_sel) |-> (!phys_we && !phys_wp));

    assert_we_source_R8: assert property (@(posedge clk) disable iff (rst)
        phys_we |-> (cpu_valid && cpu_we && !reg_sel));

    assert_we_wp_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(phys_we && phys_wp));

    assert_quick_select_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && reg_sel && cpu_we && cpu_addr[7:4] == 4'hE)
        |=> active_set == SET_W'($past(cpu_addr[3:0])));

    assert_irq_clear_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_clear |=> !irq);

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(ctrl_clear));

endmodule

bind page_mmu page_mmu_chk #(.SET_W(SET_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_valid  (cpu_valid),
    .reg_sel    (reg_sel),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .phys_addr  (phys_addr),
    .phys_we    (phys_we),
    .phys_wp    (phys_wp),
    .irq        (irq),
    .enable     (en_q),
    .active_set (act_q)
);

// File: tb/page_mmu_test.sv
module page_mmu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0, reg_sel = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [25:0] phys_addr;
    logic        phys_we, phys_wp, irq;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [7:0]  s_rd;
    logic [25:0] s_pa;
    logic        s_we, s_wp;

    always #2 clk = ~clk;

    page_mmu uut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .reg_sel(reg_sel),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .phys_addr(phys_addr), .phys_we(phys_we),
        .phys_wp(phys_wp), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus(input logic s, input logic w,
                       input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_valid = 1'b1; reg_sel = s; cpu_we = w; cpu_addr = a; cpu_wdata = d;
        #1;
        s_rd = cpu_rdata; s_pa = phys_addr; s_we = phys_we; s_wp = phys_wp;
        @(posedge clk);
        #1;
        cpu_valid = 1'b0; reg_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] off, input logic [7:0] d);
        bus(1'b1, 1'b1, {8'h00, off}, d);
    endtask

    task automatic reg_rd(input logic [7:0] off);
        bus(1'b1, 1'b0, {8'h00, off}, 8'h00);
    endtask

    // Set 5 contents: scrambled pages, page 4 protected, page 6 interrupting
    function automatic logic [15:0] e5(input int n);
        logic [13:0] p;
        p = 14'((n * 167 + 4660) & 16'h3FFF);
        return {n == 4, n == 6, p};
    endfunction

    function automatic logic [15:0] addr_of(input int n);
        return {4'(n), 12'((n * 273 + 5) & 12'hFFF)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        reg_rd(8'h00); chk("R1", "ctrl after reset", s_rd, 8'h00);
        reg_rd(8'h01); chk("R1", "edit set after reset", s_rd, 8'h00);
        reg_rd(8'h02); chk("R1", "active set after reset", s_rd, 8'h00);
        chk("R1", "irq after reset", irq, 1'b0);

        repeat (256 * 16 + 8) @(posedge clk);

        // R1 / R6 identity fill over every set
        for (int s = 0; s < 256; s++) begin
            reg_wr(8'h01, 8'(s));
            for (int n = 0; n < 16; n++) begin
                reg_rd(8'(8'h10 + n)); chk("R1", "identity low byte", s_rd, 8'(n));
                reg_rd(8'(8'h20 + n)); chk("R1", "identity high byte", s_rd, 8'h00);
            end
        end

        // Program set 5 through the edit window
        reg_wr(8'h01, 8'd5);
        for (int n = 0; n < 16; n++) begin
            reg_wr(8'(8'h10 + n), e5(n)[7:0]);
            reg_wr(8'(8'h20 + n), e5(n)[15:8]);
        end
        for (int n = 0; n < 16; n++) begin
            reg_rd(8'(8'h10 + n)); chk("R6", "set5 low readback", s_rd, e5(n)[7:0]);
            reg_rd(8'(8'h20 + n)); chk("R6", "set5 high readback", s_rd, e5(n)[15:8]);
        end
        reg_wr(8'h02, 8'd5);
        reg_rd(8'h02); chk("R5", "active set readback", s_rd, 8'd5);

        // R2 disabled: flat addresses, writes pass, no interrupt
        for (int n = 0; n < 16; n++) begin
            bus(1'b0, 1'b1, addr_of(n), 8'hA5);
            chk("R2", "disabled phys_addr", s_pa, 32'(addr_of(n)));
            chk("R2", "disabled write passes", {s_we, s_wp}, 2'b10);
        end
        chk("R2", "no irq while disabled", irq, 1'b0);

        // R3 / R8 enabled sweep
        reg_wr(8'h00, 8'h01);
        for (int n = 0; n < 16; n++) begin
            bus(1'b0, 1'b1, addr_of(n), 8'h3C);
            chk("R3", "translated addr", s_pa, {e5(n)[13:0], addr_of(n)[11:0]});
            chk("R8", "write protect", {s_we, s_wp}, {n != 4, n == 4});
        end
        bus(1'b0, 1'b0, addr_of(4), 8'h00);
        chk("R8", "read of protected page", {s_we, s_wp}, 2'b00);
        chk("R8", "read translated", s_pa, {e5(4)[13:0], addr_of(4)[11:0]});

        // R9 / R4 interrupt
        reg_wr(8'h00, 8'h03);
        chk("R4", "irq cleared", irq, 1'b0);
        bus(1'b0, 1'b0, addr_of(5), 8'h00);
        chk("R9", "unflagged page no irq", irq, 1'b0);
        bus(1'b0, 1'b0, addr_of(6), 8'h00);
        chk("R9", "flagged page raises irq", irq, 1'b1);
        bus(1'b0, 1'b0, addr_of(2), 8'h00);
        chk("R9", "irq held", irq, 1'b1);
        reg_rd(8'h00); chk("R4", "ctrl shows irq", s_rd, 8'h03);
        reg_wr(8'h00, 8'h01);
        chk("R4", "write without clear bit keeps irq", irq, 1'b1);
        reg_wr(8'h00, 8'h03);
        chk("R4", "clear bit drops irq", irq, 1'b0);
        reg_rd(8'h00); chk("R4", "ctrl after clear", s_rd, 8'h01);

        // R10 register access to an address whose high byte names page 6
        bus(1'b1, 1'b1, 16'h6002, 8'd5);
        chk("R10", "reg write no phys strobe", {s_we, s_wp}, 2'b00);
        chk("R10", "reg access no irq", irq, 1'b0);
        bus(1'b1, 1'b0, 16'h4000, 8'h00);
        chk("R10", "reg read no phys strobe", {s_we, s_wp}, 2'b00);

        // R5 / R11 independent edit set, aliased page
        reg_wr(8'h01, 8'd9);
        for (int n = 0; n < 16; n++) begin
            reg_wr(8'(8'h10 + n), 8'hA5);
            reg_wr(8'(8'h20 + n), 8'h02);
        end
        bus(1'b0, 1'b0, addr_of(0), 8'h00);
        chk("R5", "active set unaffected by edits", s_pa, {e5(0)[13:0], addr_of(0)[11:0]});
        reg_rd(8'h01); chk("R5", "edit set readback", s_rd, 8'd9);
        reg_rd(8'h02); chk("R5", "active set kept", s_rd, 8'd5);
        reg_wr(8'h02, 8'd9);
        for (int n = 0; n < 16; n++) begin
            bus(1'b0, 1'b0, addr_of(n), 8'h00);
            chk("R11", "aliased page", s_pa, {14'h02A5, addr_of(n)[11:0]});
        end

        // R7 quick select
        reg_wr(8'hE3, 8'h00);
        reg_rd(8'h02); chk("R7", "quick active", s_rd, 8'd3);
        reg_rd(8'h01); chk("R7", "edit set kept", s_rd, 8'd9);
        bus(1'b0, 1'b0, addr_of(7), 8'h00);
        chk("R7", "set 3 identity", s_pa, 32'(addr_of(7)));
        reg_wr(8'hEF, 8'h00);
        reg_rd(8'h02); chk("R7", "quick active 15", s_rd, 8'd15);

        // R2 back to disabled
        reg_wr(8'h02, 8'd5);
        reg_wr(8'h00, 8'h00);
        bus(1'b0, 1'b1, addr_of(4), 8'h00);
        chk("R2", "disabled protect ignored", {s_we, s_wp}, 2'b10);
        chk("R2", "disabled flat again", s_pa, 32'(addr_of(4)));
        bus(1'b0, 1'b0, addr_of(6), 8'h00);
        chk("R2", "disabled no irq", irq, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule